// File: doc/BRIEF.md
# Calendar Real-Time Clock with Deferred Register Writes

The block keeps wall-clock time and a calendar date: seconds, minutes, hours, day of month, month, and a year held as an offset from 1970 (usable range 1970 to 2033). It has two packed 32-bit registers, one for time and one for date, plus a status register. All three sit behind a plain 32-bit register bus. A one-cycle enable, `tick_1hz`, advances the clock by one second each time it is high on a clock edge. Seconds, minutes and hours carry into one another. The day follows the length of the current month. February has a 29th day only when the stored leap flag is set.

Software writes to the time and date registers are not applied at once. Each of the two registers has its own commit channel. The channel is a two-state machine with states `CH_IDLE` and `CH_PEND`:
- The transition *accept* (`CH_IDLE` to `CH_PEND`) happens on a bus write to that register. It latches the written word and raises a busy bit in the status register.
- The transition *commit* (`CH_PEND` to `CH_IDLE`) happens on the `COMMIT_TICKS`-th tick counted after the accepting edge. On that edge the latched value replaces the register contents and the busy bit drops.

While a channel is in `CH_PEND`, reads return the old, still-advancing value, and any further write to that register is dropped. Software polls the busy bit before it writes again.

Top module: `rtc_cal`

## Requirements
- R1: After reset, time reads 0x00000000, date reads 0x00000101 (day 1, month 1, year offset 0, leap flag clear) and the status register reads 0.
- R2: Reads are combinational from `bus_addr`. The status register is at 0x00, date at 0x10 and time at 0x14. Every other address reads 0. Writes to any address other than 0x10 and 0x14 change no register.
- R3: The time word holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. The date word holds day in bits 4:0, month (1 to 12) in bits 11:8, year offset from 1970 in bits 21:16 and the leap flag in bit 22. All other bits are dropped on write and read as 0.
- R4: A write to an idle time channel sets status bit 8 from the next cycle. A write to an idle date channel sets status bit 7. Status bit 9 and all other status bits always read 0.
- R5: An accepted write takes effect on the `COMMIT_TICKS`-th tick after the accepting edge. A tick on the accepting edge itself is not counted. Until that edge the register keeps its old, advancing value. The busy bit clears on the same edge.
- R6: A write to a register whose busy bit is set is ignored. It changes neither the pending value nor the commit timing.
- R7: With no tick, time and date hold. Each tick adds one second. Seconds roll 59 to 0 into minutes, minutes roll 59 to 0 into hours, and hours roll 23 to 0 into the day.
- R8: The day rolls to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days, month 2 has 28 days (29 with the leap flag set), and all other months have 31.
- R9: Month 12 rolls to 1 and increments the year offset. On that roll the leap flag is recomputed as set exactly when the new year offset modulo 4 equals 2.
- R10: On the tick where a time commit lands, time takes the written value and no carry reaches the date. A date commit on a tick replaces any carry of that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timekeeping clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle enable; each high edge advances one second |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |

## Verification
The bench builds the block with `COMMIT_TICKS` = 3 and an 8-bit address. That keeps each deferred write to three ticks, so commit landings, dropped second writes and a commit that coincides with a midnight roll fit in a few cycles. The tick is driven on consecutive cycles and also sparsely. With time and date preloaded just before boundaries through the normal write path, the leap and non-leap February ends, a 30-day month, the year roll with leap recomputation and the year offset moving past 2032 are all reached within a short run.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } hms_t;

    typedef struct packed {
        logic       leap;
        logic [5:0] yr;
        logic [3:0] mo;
        logic [4:0] dy;
    } ymd_t;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } chan_state_e;

    localparam logic [7:0] REG_STATUS = 8'h00;
    localparam logic [7:0] REG_DATE   = 8'h10;
    localparam logic [7:0] REG_TIME   = 8'h14;

    localparam int BUSY_DATE_POS = 7;
    localparam int BUSY_TIME_POS = 8;

    localparam hms_t HMS_RESET = '{hr: 5'd0, mn: 6'd0, sc: 6'd0};
    localparam ymd_t YMD_RESET = '{leap: 1'b0, yr: 6'd0, mo: 4'd1, dy: 5'd1};

    function automatic logic [31:0] hms_to_word(input hms_t t);
        return {11'd0, t.hr, 2'd0, t.mn, 2'd0, t.sc};
    endfunction

    function automatic logic [31:0] ymd_to_word(input ymd_t d);
        return {9'd0, d.leap, d.yr, 4'd0, d.mo, 3'd0, d.dy};
    endfunction

    function automatic hms_t word_to_hms(input logic [31:0] w);
        return '{hr: w[20:16], mn: w[13:8], sc: w[5:0]};
    endfunction

    function automatic ymd_t word_to_ymd(input logic [31:0] w);
        return '{leap: w[22], yr: w[21:16], mo: w[11:8], dy: w[4:0]};
    endfunction

    // Offset 2 from 1970 is 1972, the first leap year in range.
    function automatic logic year_is_leap(input logic [5:0] yr);
        return (yr[1:0] == 2'b10);
    endfunction

    function automatic logic [4:0] days_in_month(input logic [3:0] mo, input logic leap);
        logic [4:0] n;
        unique case (mo)
            4'd4, 4'd6, 4'd9, 4'd11: n = 5'd30;
            4'd2:                    n = leap ? 5'd29 : 5'd28;
            default:                 n = 5'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_commit_chan.sv
module rtc_commit_chan
    import rtc_cal_pkg::*;
#(
    parameter int WIDTH        = 16,
    parameter int COMMIT_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    output logic             busy,
    output logic             commit,
    output logic [WIDTH-1:0] held
);

    localparam int CNT_W = (COMMIT_TICKS > 1) ? $clog2(COMMIT_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(COMMIT_TICKS - 1);

    chan_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_tick;

    assign last_tick = tick && (cnt_q == LAST_CNT);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (wr_req)    state_d = CH_PEND;   // accept
            CH_PEND: if (last_tick) state_d = CH_IDLE;   // commit
            default:                state_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // captured value and tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held  <= '0;
            cnt_q <= '0;
        end else if (state_q == CH_IDLE) begin
            if (wr_req) begin
                held  <= wr_data;
                cnt_q <= '0;
            end
        end else if (tick && !last_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy   = (state_q == CH_PEND);
        commit = (state_q == CH_PEND) && last_tick;
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !busy) |=> busy);                                   // R4
    AST_BUSY_DROPS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));                                  // R5
    AST_PENDING_VALUE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_req) |=> $stable(held));                           // R6

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load_time,
    input  hms_t time_val,
    input  logic load_date,
    input  ymd_t date_val,
    output hms_t time_q,
    output ymd_t date_q
);

    hms_t       time_d;
    ymd_t       date_d;
    logic       sc_wrap, mn_wrap, hr_wrap, day_carry, dy_wrap, mo_wrap;
    logic [4:0] month_len;
    logic [5:0] yr_next;

    always_comb begin
        sc_wrap   = tick && (time_q.sc >= 6'd59);
        mn_wrap   = sc_wrap && (time_q.mn >= 6'd59);
        hr_wrap   = mn_wrap && (time_q.hr >= 5'd23);
        day_carry = hr_wrap && !load_time;
        month_len = days_in_month(date_q.mo, date_q.leap);
        dy_wrap   = day_carry && (date_q.dy >= month_len);
        mo_wrap   = dy_wrap && (date_q.mo >= 4'd12);
        yr_next   = date_q.yr + 6'd1;
    end

    // time of day
    always_comb begin
        time_d = time_q;
        if (tick) begin
            time_d.sc = sc_wrap ? 6'd0 : time_q.sc + 6'd1;
            if (sc_wrap) time_d.mn = mn_wrap ? 6'd0 : time_q.mn + 6'd1;
            if (mn_wrap) time_d.hr = hr_wrap ? 5'd0 : time_q.hr + 5'd1;
        end
        if (load_time) time_d = time_val;
    end

    // calendar date
    always_comb begin
        date_d = date_q;
        if (day_carry) begin
            date_d.dy = dy_wrap ? 5'd1 : date_q.dy + 5'd1;
            if (dy_wrap) date_d.mo = mo_wrap ? 4'd1 : date_q.mo + 4'd1;
            if (mo_wrap) begin
                date_d.yr   = yr_next;
                date_d.leap = year_is_leap(yr_next);
            end
        end
        if (load_date) date_d = date_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= HMS_RESET;
            date_q <= YMD_RESET;
        end else begin
            time_q <= time_d;
            date_q <= date_d;
        end
    end

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(time_q) && $stable(date_q)));               // R7
    AST_SECOND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_time && time_q.sc < 6'd59)
        |=> (time_q.sc == $past(time_q.sc) + 6'd1));                   // R7
    AST_NO_CARRY_ON_TIME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && load_time && !load_date) |=> $stable(date_q));        // R10
    AST_LEAP_FEB_29: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_time && !load_date && time_q.hr == 5'd23 &&
         time_q.mn == 6'd59 && time_q.sc == 6'd59 && date_q.mo == 4'd2 &&
         date_q.dy == 5'd28 && date_q.leap) |=> (date_q.dy == 5'd29)); // R8

endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              busy_date,
    input  logic              busy_time,
    input  hms_t              time_q,
    input  ymd_t              date_q,
    output logic              wr_date,
    output logic              wr_time,
    output hms_t              time_wval,
    output ymd_t              date_wval,
    output logic [31:0]       bus_rdata
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
    localparam logic [ADDR_W-1:0] A_DATE   = ADDR_W'(REG_DATE);
    localparam logic [ADDR_W-1:0] A_TIME   = ADDR_W'(REG_TIME);

    logic [31:0] status_word;
    logic        wdata_unused;

    assign wdata_unused = ^{bus_wdata[31:23], bus_wdata[15:14], bus_wdata[7:6]};

    always_comb begin
        wr_date   = bus_wr && (bus_addr == A_DATE);
        wr_time   = bus_wr && (bus_addr == A_TIME);
        time_wval = word_to_hms(bus_wdata);
        date_wval = word_to_ymd(bus_wdata);
    end

    always_comb begin
        status_word                = '0;
        status_word[BUSY_DATE_POS] = busy_date;
        status_word[BUSY_TIME_POS] = busy_time;
    end

    always_comb begin
        if (bus_addr == A_STATUS)    bus_rdata = status_word;
        else if (bus_addr == A_DATE) bus_rdata = ymd_to_word(date_q);
        else if (bus_addr == A_TIME) bus_rdata = hms_to_word(time_q);
        else                         bus_rdata = '0;
    end

endmodule

// File: rtl/rtc_cal.sv
module rtc_cal
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int COMMIT_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    logic wr_date, wr_time;
    logic busy_date, busy_time;
    logic commit_date, commit_time;
    hms_t time_q, time_wval, time_held;
    ymd_t date_q, date_wval, date_held;

    rtc_regbank #(.ADDR_W(ADDR_W)) u_regs (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy_date (busy_date),
        .busy_time (busy_time),
        .time_q    (time_q),
        .date_q    (date_q),
        .wr_date   (wr_date),
        .wr_time   (wr_time),
        .time_wval (time_wval),
        .date_wval (date_wval),
        .bus_rdata (bus_rdata)
    );

    rtc_commit_chan #(.WIDTH($bits(ymd_t)), .COMMIT_TICKS(COMMIT_TICKS)) u_date_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .wr_req  (wr_date),
        .wr_data (date_wval),
        .busy    (busy_date),
        .commit  (commit_date),
        .held    (date_held)
    );

    rtc_commit_chan #(.WIDTH($bits(hms_t)), .COMMIT_TICKS(COMMIT_TICKS)) u_time_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .wr_req  (wr_time),
        .wr_data (time_wval),
        .busy    (busy_time),
        .commit  (commit_time),
        .held    (time_held)
    );

    rtc_calendar_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1hz),
        .load_time (commit_time),
        .time_val  (time_held),
        .load_date (commit_date),
        .date_val  (date_held),
        .time_q    (time_q),
        .date_q    (date_q)
    );

    AST_OLD_TIME_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_time && !tick_1hz) |=> $stable(time_q));                 // R5
    AST_DATE_WRITE_FLAGS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_date && !busy_date) |=> busy_date);                        // R4

endmodule

// File: tb/rtc_cal_tb_top.sv
module rtc_cal_tb_top;

    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;

    always #10 clk = ~clk;

    rtc_cal #(.ADDR_W(8), .COMMIT_TICKS(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata)
    );

    // ---------------- behavioural reference model ----------------
    int m_sc = 0, m_mn = 0, m_hr = 0;
    int m_dy = 1, m_mo = 1, m_yr = 0, m_lp = 0;
    int pend_t = 0, cnt_t = 0, pend_d = 0, cnt_d = 0;
    logic [31:0] val_t = 0, val_d = 0;

    int checks = 0, errors = 0, rr = 0;
    bit done = 0;
    string phase = "R1 reset";

    function automatic int month_len(int mo, int lp);
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        if (mo == 2) return lp ? 29 : 28;
        return 31;
    endfunction

    function automatic logic [31:0] tm(int h, int m, int s);
        return (h << 16) | (m << 8) | s;
    endfunction

    function automatic logic [31:0] dt(int y, int m, int d, int lp);
        return (lp << 22) | (y << 16) | (m << 8) | d;
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        if (a == 8'h00) return (pend_d << 7) | (pend_t << 8);
        if (a == 8'h10) return dt(m_yr, m_mo, m_dy, m_lp);
        if (a == 8'h14) return tm(m_hr, m_mn, m_sc);
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sc = 0; m_mn = 0; m_hr = 0;
            m_dy = 1; m_mo = 1; m_yr = 0; m_lp = 0;
            pend_t = 0; cnt_t = 0; pend_d = 0; cnt_d = 0;
        end else begin
            automatic bit ct = pend_t && tick && cnt_t == N - 1;
            automatic bit cd = pend_d && tick && cnt_d == N - 1;
            automatic bit carry = 0;
            if (tick) begin
                if (m_sc == 59) begin
                    m_sc = 0;
                    if (m_mn == 59) begin
                        m_mn = 0;
                        if (m_hr == 23) begin m_hr = 0; carry = 1; end
                        else m_hr++;
                    end else m_mn++;
                end else m_sc++;
            end
            if (ct) begin
                m_hr = val_t[20:16]; m_mn = val_t[13:8]; m_sc = val_t[5:0];
                carry = 0;
            end
            if (carry) begin
                if (m_dy >= month_len(m_mo, m_lp)) begin
                    m_dy = 1;
                    if (m_mo == 12) begin
                        m_mo = 1;
                        m_yr = (m_yr + 1) % 64;
                        m_lp = ((m_yr + 1970) % 4 == 0);
                    end else m_mo++;
                end else m_dy++;
            end
            if (cd) begin
                m_lp = val_d[22]; m_yr = val_d[21:16]; m_mo = val_d[11:8]; m_dy = val_d[4:0];
            end
            if (pend_t) begin
                if (tick) begin
                    if (cnt_t == N - 1) pend_t = 0; else cnt_t++;
                end
            end else if (wr && addr == 8'h14) begin
                pend_t = 1; cnt_t = 0; val_t = wdata;
            end
            if (pend_d) begin
                if (tick) begin
                    if (cnt_d == N - 1) pend_d = 0; else cnt_d++;
                end
            end else if (wr && addr == 8'h10) begin
                pend_d = 1; cnt_d = 0; val_d = wdata;
            end
        end
    end

    // ---------------- stimulus and comparison ----------------
    task automatic check_now();
        automatic logic [31:0] exp = model_read(addr);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s addr %02h: got %08h expected %08h", phase, addr, rdata, exp);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic t);
        @(negedge clk);
        wr = w; addr = a; wdata = d; tick = t;
        #1 check_now();
    endtask

    task automatic idle(input logic t);
        logic [7:0] a;
        a = (rr == 0) ? 8'h00 : (rr == 1) ? 8'h10 : 8'h14;
        rr = (rr + 1) % 3;
        step(1'b0, a, 32'h0, t);
    endtask

    task automatic load(input logic [31:0] t_word, input logic [31:0] d_word);
        step(1'b1, 8'h14, t_word, 1'b0);
        step(1'b1, 8'h10, d_word, 1'b0);
        repeat (N) idle(1'b1);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog: got hung run expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        phase = "R1 reset";
        repeat (3) idle(1'b1);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) idle(1'b0);

        phase = "R2 map";
        step(1'b0, 8'h04, 0, 1'b0);
        step(1'b0, 8'h18, 0, 1'b0);
        step(1'b0, 8'hFC, 0, 1'b0);
        step(1'b1, 8'h04, 32'hFFFF_FFFF, 1'b0);
        step(1'b1, 8'h00, 32'hFFFF_FFFF, 1'b0);
        step(1'b1, 8'h11, 32'h0040_0000, 1'b0);
        repeat (3) idle(1'b0);

        phase = "R4 busy flags";
        step(1'b1, 8'h14, tm(23, 59, 58), 1'b0);
        repeat (3) idle(1'b0);
        step(1'b1, 8'h10, dt(44, 1, 31, 0), 1'b1);
        repeat (3) idle(1'b0);

        phase = "R6 write while busy";
        step(1'b1, 8'h14, tm(1, 2, 3), 1'b0);
        step(1'b1, 8'h10, dt(5, 5, 5, 0), 1'b0);
        step(1'b0, 8'h00, 0, 1'b0);

        phase = "R5 deferred commit";
        repeat (4) begin idle(1'b1); idle(1'b0); idle(1'b0); end

        phase = "R7 rollover";
        repeat (8) idle(1'b1);
        repeat (3) idle(1'b0);
        load(tm(12, 59, 58), dt(44, 3, 10, 0));
        repeat (6) idle(1'b1);

        phase = "R8 month length";
        load(tm(23, 59, 59), dt(30, 2, 28, 1));
        repeat (3) idle(1'b1);
        load(tm(23, 59, 59), dt(30, 2, 29, 1));
        repeat (3) idle(1'b1);
        load(tm(23, 59, 59), dt(31, 2, 28, 0));
        repeat (3) idle(1'b1);
        load(tm(23, 59, 59), dt(31, 4, 30, 0));
        repeat (3) idle(1'b1);
        load(tm(23, 59, 59), dt(31, 7, 30, 0));
        repeat (3) idle(1'b1);

        phase = "R9 year roll";
        load(tm(23, 59, 59), dt(61, 12, 31, 0));
        repeat (3) idle(1'b1);
        load(tm(23, 59, 59), dt(62, 12, 31, 1));
        repeat (3) idle(1'b1);

        phase = "R3 field masking";
        load(32'hFFE0_C0C0 | tm(7, 8, 9), 32'hFF80_F0E0 | dt(50, 9, 15, 0));
        repeat (3) idle(1'b0);
        load(tm(23, 59, 59), dt(50, 9, 15, 1));
        repeat (3) idle(1'b1);

        phase = "R10 commit at midnight";
        load(tm(23, 59, 57), dt(40, 6, 30, 0));
        step(1'b1, 8'h14, tm(10, 0, 0), 1'b0);
        repeat (3) idle(1'b1);
        repeat (3) idle(1'b0);
        load(tm(23, 59, 58), dt(40, 6, 30, 0));
        step(1'b1, 8'h10, dt(40, 8, 3, 0), 1'b0);
        repeat (4) idle(1'b1);
        repeat (3) idle(1'b0);

        phase = "R7 sparse ticks";
        for (int i = 0; i < 300; i++) begin
            if (i % 50 == 7) step(1'b1, 8'h14, tm(i % 24, 59, 50), 1'b0);
            else if (i % 50 == 20) step(1'b1, 8'h10, dt(i % 64, 12, 31, 0), 1'b1);
            else idle(i % 3 == 0);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule